// File: doc/BRIEF.md
# Three-Phase Centre-Aligned PWM Generator with Deadtime

This block drives three inverter legs. A free-running counter covers one switching period. Its length is set in system clocks by a period register. For each leg, an on-time register places a pulse at the centre of that period. The block drives two active-low outputs per leg, six outputs in total: a main output and its complement. The edges of the two outputs are pulled apart by a programmable, always-even deadtime. A pulse whose net width would be shorter than a programmable minimum is dropped completely.

A host loads the block through a synchronous write port. The three on-times form one set. A new set takes effect only after all three have been written. It is moved into the active edges at the next period boundary, provided its last write arrives early enough for the edges to be computed. An external stop input forces all six outputs inactive (high) in the same clock. A one-clock sync pulse marks the start of every period, so that other blocks can align to it.

Top module: `pwm3_center`

## Requirements
- R1: After reset all six outputs are high and sync_o is low. While the period register is zero the outputs stay high and no sync pulse appears.
- R2: `wr_sel` selects the register that is written:
  - 0: period, 12 bits.
  - 1, 2, 3: on-time for legs 0, 1 and 2.
  - 4: deadtime, 7 bits, with bit 0 forced to zero.
  - 5: minimum pulse, 7 bits.
  
  With a non-zero period P, sync_o is high for exactly one clock in every P clocks.
- R3: Number the clocks of a period t = 0 .. P-1, with sync_o high at t = 0. Let D be the on-time, h half the even deadtime, and lo = floor((P-D)/2). The main output of a leg is low exactly for lo+h <= t < lo+D-h.
- R4: The complement of a leg is low exactly when t < lo-h or t >= lo+D+h. A main output and its complement are never low together.
- R5: A new on-time set is used only after all three on-time registers have been written. If only some of them are written, the previous set stays in use.
- R6: An on-time set is used from the next period if its last write is accepted on the clock edge that ends counter value P-5 or earlier, which is sample t = P-6 or earlier. A later write is used one period after that.
- R7: If D minus the even deadtime is less than the minimum-pulse value, the main output of that leg is high for the whole period and its complement is low for the whole period.
- R8: If D >= P, the main output of that leg is low for the whole period and its complement is high for the whole period. This rule takes priority over R7.
- R9: While stop is high, all six outputs are high in the same clock. After stop falls, the outputs follow R3 and R4 again from the next clock.
- R10: Changes to deadtime and minimum pulse take effect at the next period boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select (see R2) |
| wr_data | input | 12 | Write data |
| stop | input | 1 | Forces all outputs high while asserted |
| main_n | output | 3 | Active-low main output per leg |
| comp_n | output | 3 | Active-low complement output per leg |
| sync_o | output | 1 | One-clock pulse at the start of each period |

## Verification
The assertions assume a period of either zero or at least eight clocks, and no write of a period of one. They also assume that on-time writes are never timed so that the staging window is skipped on purpose. The stimulus draws periods from 8 to 200, on-times up to a little above the period, odd and even deadtimes, and minimum-pulse values. It waits enough period boundaries for a new set to reach the active edges before it compares a whole period. Directed cases cover the deletion and full-on boundaries, partial sets, writes one clock either side of the staging window, stop, and a zero period.

// File: rtl/pwm3_pkg.sv
// Shared constants and types for the three-phase PWM generator.
// Assumes the counter width plus two guard bits fits in EDGE_W.
package pwm3_pkg;
    localparam int EDGE_W = 16;
    localparam int NPH    = 3;

    typedef enum logic [2:0] {
        SEL_PERIOD = 3'd0,
        SEL_ON_0   = 3'd1,
        SEL_ON_1   = 3'd2,
        SEL_ON_2   = 3'd3,
        SEL_DEAD   = 3'd4,
        SEL_MINPW  = 3'd5
    } sel_e;

    // Main output low for m_lo <= t < m_hi; complement high for c_lo <= t < c_hi.
    typedef struct packed {
        logic signed [EDGE_W-1:0] m_lo;
        logic signed [EDGE_W-1:0] m_hi;
        logic signed [EDGE_W-1:0] c_lo;
        logic signed [EDGE_W-1:0] c_hi;
    } edge_t;
endpackage

// File: rtl/pwm3_regs.sv
// Register file: period, deadtime and minimum pulse are written directly.
// The on-times go to shadow registers. A complete set of three moves to the
// stage registers when the top opens the staging window (win).
// Assumes win is a single-cycle pulse, once per period.
module pwm3_regs import pwm3_pkg::*; #(
    parameter int CW  = 12,
    parameter int DTW = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [2:0]              wr_sel,
    input  logic [CW-1:0]           wr_data,
    input  logic                    win,
    output logic [CW-1:0]           per_q,
    output logic [DTW-1:0]          dt_q,
    output logic [DTW-1:0]          pd_q,
    output logic [NPH-1:0][CW-1:0]  stage
);
    logic [NPH-1:0][CW-1:0] shadow;
    logic [NPH-1:0]         mask;
    logic [NPH-1:0]         wr_hit;
    logic                   take;

    // Decode which on-time register this write targets.
    always_comb begin
        for (int i = 0; i < NPH; i++)
            wr_hit[i] = wr_en && (wr_sel == 3'(int'(SEL_ON_0) + i));
    end

    assign take = win && (&mask);

    // Directly written registers; deadtime bit 0 is always stored as zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_q <= '0;
            dt_q  <= '0;
            pd_q  <= '0;
        end else if (wr_en) begin
            if (wr_sel == SEL_PERIOD) per_q <= wr_data;
            if (wr_sel == SEL_DEAD)   dt_q  <= {wr_data[DTW-1:1], 1'b0};
            if (wr_sel == SEL_MINPW)  pd_q  <= wr_data[DTW-1:0];
        end
    end

    // Shadow capture, completeness mask and atomic transfer to stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow <= '0;
            mask   <= '0;
            stage  <= '0;
        end else begin
            for (int i = 0; i < NPH; i++)
                if (wr_hit[i]) shadow[i] <= wr_data;
            mask <= (take ? '0 : mask) | wr_hit;
            if (take) stage <= shadow;
        end
    end

    // R6: the staged set only moves when the staging window was open.
    p_stage_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(stage) |-> $past(win))
        else $error("stage changed outside staging window");
endmodule

// File: rtl/pwm3_edge_calc.sv
// Computes the edge set of one leg from period, on-time, even deadtime and
// minimum pulse. Full-on takes priority over deletion.
// Purely combinational; assumes CW + 2 <= EDGE_W.
module pwm3_edge_calc import pwm3_pkg::*; #(
    parameter int CW  = 12,
    parameter int DTW = 7
) (
    input  logic [CW-1:0]  per,
    input  logic [CW-1:0]  duty,
    input  logic [DTW-1:0] dt,
    input  logic [DTW-1:0] pd,
    output edge_t          edges
);
    logic signed [EDGE_W-1:0] p_s, d_s, dt_s, pd_s, h_s, lo_s;

    assign p_s  = signed'(EDGE_W'(per));
    assign d_s  = signed'(EDGE_W'(duty));
    assign dt_s = signed'(EDGE_W'(dt));
    assign pd_s = signed'(EDGE_W'(pd));
    assign h_s  = dt_s >>> 1;
    assign lo_s = (p_s - d_s) >>> 1;

    // Select full-on, deleted or centred-with-deadtime edges.
    always_comb begin
        if (d_s >= p_s) begin
            edges.m_lo = '0;
            edges.m_hi = p_s;
            edges.c_lo = '0;
            edges.c_hi = p_s;
        end else if ((d_s - dt_s) < pd_s) begin
            edges.m_lo = '0;
            edges.m_hi = '0;
            edges.c_lo = '0;
            edges.c_hi = '0;
        end else begin
            edges.m_lo = lo_s + h_s;
            edges.m_hi = lo_s + d_s - h_s;
            edges.c_lo = lo_s - h_s;
            edges.c_hi = lo_s + d_s + h_s;
        end
    end
endmodule

// File: rtl/pwm3_phase_cmp.sv
// Compares the period counter with the active edges of one leg.
// Combinational; the top registers the result.
module pwm3_phase_cmp import pwm3_pkg::*; #(
    parameter int CW = 12
) (
    input  logic [CW-1:0] cnt,
    input  edge_t         edges,
    output logic          main_on,
    output logic          comp_off
);
    logic signed [EDGE_W-1:0] c_s;

    assign c_s = signed'(EDGE_W'(cnt));

    // Window tests for the main output and the complement blanking interval.
    always_comb begin
        main_on  = (c_s >= edges.m_lo) && (c_s < edges.m_hi);
        comp_off = (c_s >= edges.c_lo) && (c_s < edges.c_hi);
    end
endmodule

// File: rtl/pwm3_center.sv
// Three-phase centre-aligned PWM top. It holds the period counter, the
// staging window four clocks before the wrap, the active edge registers
// loaded at the wrap, and registered drives with a combinational stop gate.
// Assumes a period of zero (idle) or at least eight clocks.
module pwm3_center import pwm3_pkg::*; #(
    parameter int CW  = 12,
    parameter int DTW = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [2:0]     wr_sel,
    input  logic [CW-1:0]  wr_data,
    input  logic           stop,
    output logic [NPH-1:0] main_n,
    output logic [NPH-1:0] comp_n,
    output logic           sync_o
);
    localparam int LEAD = 4;

    logic [CW-1:0]          per_q;
    logic [DTW-1:0]         dt_q, pd_q;
    logic [NPH-1:0][CW-1:0] stage;
    logic [CW-1:0]          cnt;
    logic                   run, wrap, win, valid;
    edge_t                  calc [NPH];
    edge_t                  act  [NPH];
    logic [NPH-1:0]         m_on, c_off;
    logic [NPH-1:0]         drv_main_n, drv_comp_n;

    assign run  = (per_q != '0);
    assign wrap = run && (cnt >= per_q - CW'(1));
    assign win  = (per_q > CW'(LEAD)) && (cnt == per_q - CW'(LEAD));

    pwm3_regs #(.CW(CW), .DTW(DTW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .win(win), .per_q(per_q), .dt_q(dt_q),
        .pd_q(pd_q), .stage(stage)
    );

    for (genvar g = 0; g < NPH; g++) begin : g_leg
        pwm3_edge_calc #(.CW(CW), .DTW(DTW)) u_calc (
            .per(per_q), .duty(stage[g]), .dt(dt_q), .pd(pd_q), .edges(calc[g])
        );
        pwm3_phase_cmp #(.CW(CW)) u_cmp (
            .cnt(cnt), .edges(act[g]), .main_on(m_on[g]), .comp_off(c_off[g])
        );
        // R4: a leg never has both switches on.
        p_pair_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !(!main_n[g] && !comp_n[g]))
            else $error("leg %0d both outputs active", g);
    end

    // Period counter; restarts at zero at the wrap and idles at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (wrap) cnt <= '0;
        else if (run)  cnt <= cnt + CW'(1);
        else           cnt <= '0;
    end

    // Active edges are loaded at the wrap so a new period starts cleanly.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            for (int i = 0; i < NPH; i++) act[i] <= '0;
        end else if (!run) begin
            valid <= 1'b0;
        end else if (wrap) begin
            valid <= 1'b1;
            for (int i = 0; i < NPH; i++) act[i] <= calc[i];
        end
    end

    // Registered drives and sync pulse, all one clock behind the counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drv_main_n <= '1;
            drv_comp_n <= '1;
            sync_o     <= 1'b0;
        end else begin
            drv_main_n <= ~({NPH{valid && run}} & m_on);
            drv_comp_n <= ~({NPH{valid && run}} & ~c_off);
            sync_o     <= run && (cnt == '0);
        end
    end

    assign main_n = drv_main_n | {NPH{stop}};
    assign comp_n = drv_comp_n | {NPH{stop}};

    // R2: the sync pulse lasts one clock.
    p_sync_single_r2: assert property (@(posedge clk)
        disable iff (!rst_n || per_q < CW'(2))
        sync_o |=> !sync_o)
        else $error("sync pulse wider than one clock");

    // R1: a zero period keeps every output inactive.
    p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (per_q == '0 && $past(per_q) == '0) |-> ((&main_n) && (&comp_n) && !sync_o))
        else $error("output active while idle");
endmodule

// File: tb/pwm3_center_tb.sv
module pwm3_center_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [11:0] wr_data = '0;
    logic        stop = 1'b0;
    logic [2:0]  main_n, comp_n;
    logic        sync_o;

    int checks = 0;
    int errors = 0;
    int e_P = 0, e_dt = 0, e_pd = 0;
    int e_D [3] = '{0, 0, 0};
    int n_D [3] = '{0, 0, 0};

    always #4 clk = ~clk;

    pwm3_center u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .stop(stop), .main_n(main_n), .comp_n(comp_n),
        .sync_o(sync_o)
    );

    // Expected {main_low, comp_low} from R3, R4, R7, R8.
    function automatic logic [1:0] model(int P, int D, int dt, int pd, int t);
        int dte, h, lo;
        dte = dt & 126;
        h   = dte / 2;
        if (D >= P) return 2'b10;
        if (D - dte < pd) return 2'b01;
        lo = (P - D) / 2;
        return {(t >= lo + h) && (t < lo + D - h),
                !((t >= lo - h) && (t < lo + D + h))};
    endfunction

    task automatic wr(input int sel, input int data);
        wr_en = 1'b1; wr_sel = 3'(sel); wr_data = 12'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_sync();
        int n = 0;
        do begin @(negedge clk); n++; end while (!sync_o && n < 5000);
        if (!sync_o) begin
            checks++; errors++;
            $display("FAIL R2 no sync seen: sync=%b expected 1", sync_o);
        end
    endtask

    task automatic check_now(input int t, input string tag);
        logic [2:0] em, ec;
        logic [1:0] r;
        for (int i = 0; i < 3; i++) begin
            r = model(e_P, e_D[i], e_dt, e_pd, t);
            em[i] = ~r[1];
            ec[i] = ~r[0];
        end
        checks++;
        if (main_n !== em || comp_n !== ec || sync_o !== (t == 0)) begin
            errors++;
            $display("FAIL %s t=%0d: main_n=%b comp_n=%b sync=%b expected %b %b %b",
                     tag, t, main_n, comp_n, sync_o, em, ec, (t == 0));
        end
    endtask

    task automatic check_cycle(input string tag);
        wait_sync();
        for (int t = 0; t < e_P; t++) begin
            if (t > 0) @(negedge clk);
            check_now(t, tag);
        end
    endtask

    task automatic check_idle(input string tag);
        checks++;
        if (main_n !== 3'b111 || comp_n !== 3'b111 || sync_o !== 1'b0) begin
            errors++;
            $display("FAIL %s: main_n=%b comp_n=%b sync=%b expected 111 111 0",
                     tag, main_n, comp_n, sync_o);
        end
    endtask

    task automatic write_all(input int P, input int a, input int b, input int c,
                             input int dt, input int pd);
        wr(0, P); wr(4, dt); wr(5, pd); wr(1, a); wr(2, b); wr(3, c);
        e_P = P; e_dt = dt; e_pd = pd;
        e_D = '{a, b, c};
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired: run=hung expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd24681));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state and idle with zero period
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            check_idle("R1 reset/idle");
        end

        // R3 R4 R2: basic centred pulses with deadtime
        write_all(40, 10, 20, 30, 6, 0);
        repeat (2) wait_sync();
        check_cycle("R3/R4 basic");

        // R7 R8: deletion boundary and full-on, odd deadtime value (R2 LSB drop)
        write_all(60, 14, 13, 60, 5, 10);
        repeat (2) wait_sync();
        check_cycle("R7/R8 boundary");
        write_all(61, 60, 0, 1, 0, 0);
        repeat (2) wait_sync();
        check_cycle("R8/R3 near-full and empty");
        write_all(50, 75, 9, 12, 8, 3);
        repeat (2) wait_sync();
        check_cycle("R8/R7 over-period and deleted");

        // R5: partial set keeps old values
        write_all(40, 10, 20, 30, 6, 0);
        repeat (2) wait_sync();
        wr(1, 16); wr(2, 8);
        repeat (2) wait_sync();
        check_cycle("R5 partial set ignored");
        wr(3, 24);
        e_D = '{16, 8, 24};
        repeat (2) wait_sync();
        check_cycle("R5 complete set applied");

        // R6: last write at sample P-6 is in time
        wait_sync();
        wr(1, 12); wr(2, 22);
        repeat (e_P - 8) @(negedge clk);
        wr(3, 32);
        e_D = '{12, 22, 32};
        check_cycle("R6 in-time write");
        // R6: last write at sample P-5 is one period late
        wait_sync();
        wr(1, 18); wr(2, 28);
        repeat (e_P - 7) @(negedge clk);
        wr(3, 6);
        n_D = '{18, 28, 6};
        check_cycle("R6 late write keeps old");
        e_D = n_D;
        check_cycle("R6 late write applied");

        // R10: deadtime and minimum pulse change at a boundary
        wr(4, 12); wr(5, 20);
        e_dt = 12; e_pd = 20;
        repeat (2) wait_sync();
        check_cycle("R10 new deadtime/min pulse");

        // R9: stop forces all outputs high, then resume
        wait_sync();
        repeat (3) @(negedge clk);
        stop = 1'b1;
        for (int t = 4; t < 10; t++) begin
            @(negedge clk);
            checks++;
            if (main_n !== 3'b111 || comp_n !== 3'b111) begin
                errors++;
                $display("FAIL R9 stop t=%0d: main_n=%b comp_n=%b expected 111 111",
                         t, main_n, comp_n);
            end
        end
        stop = 1'b0;
        @(negedge clk);
        check_now(10, "R9 resume");

        // Random mix covering R3 R4 R7 R8
        for (int k = 0; k < 14; k++) begin
            int P, a, b, c, dt, pd;
            P  = 8 + int'($urandom % 193);
            a  = int'($urandom % (P + 12));
            b  = int'($urandom % (P + 12));
            c  = int'($urandom % (P + 12));
            dt = int'($urandom % 128);
            pd = int'($urandom % 48);
            write_all(P, a, b, c, dt, pd);
            repeat (2) wait_sync();
            check_cycle("R3/R4/R7/R8 random");
        end

        // R1: zero period returns to idle
        wr(0, 0);
        repeat (3) @(negedge clk);
        for (int k = 0; k < 20; k++) begin
            check_idle("R1 zero period");
            @(negedge clk);
        end
        finish_run();
    end
endmodule